// File: doc/BRIEF.md
# Ring Doorbell Occupancy Tracker

This block holds the runtime state of a small bank of descriptor rings that live in system memory. Each ring has a register window on a simple register bus. A producer adds entries by writing a positive count to the ring's doorbell register. A consumer removes entries by writing a negative count. The block keeps a running occupancy count, a write index and a read index for every ring. From these it derives the free-entry count and the memory addresses of the next element to write and the next element to read.

A separate configuration port loads each ring's base address, element count, element-size code and operating mode. A teardown event input raises a per-ring completion flag, which software sees in the top bit of the occupancy register. A per-ring clear strobe returns a ring's runtime state to empty in a single cycle.

The descriptor memory, the DMA engine and the firmware messaging that would drive the configuration port all sit outside this block.

Top module: `ringdb_top`

## Requirements
- R1: After reset every ring reads occupancy 0, free 0, write index 0 and read index 0. Every element address output is 0 and no overflow flag is set.
- R2: A write to the doorbell register (window offset 0x10) adds the signed value of write-data bits 7:0 to the ring's occupancy. So 0x01 adds one entry and 0xFF removes one. Write-data bits 30:8 have no effect on the count, and neither does bit 31.
- R3: The occupancy register (window offset 0x18) returns the count in bits 20:0 and the teardown flag in bit 31, with bits 30:21 zero. The count is kept modulo 2^21 and never saturates, so removing one entry from an empty ring reads 0x1FFFFF.
- R4: A positive count advances the write index by that count, and a negative count advances the read index by its magnitude. Both indices wrap modulo the ring size. The write index reads at offset 0x20 and the read index at offset 0x24.
- R5: The write and read element addresses each equal the ring base plus the index times (4 << element-size code).
- R6: The free register (window offset 0x1C) returns the ring size minus the occupancy, modulo 2^21.
- R7: A positive doorbell count arriving while free is zero sets the ring's sticky overflow flag. The occupancy still changes. Only a clear strobe or a configuration write lowers the flag.
- R8: A teardown event sets the ring's teardown flag. A doorbell write with bit 31 set clears it. When both happen in the same cycle, the event wins.
- R9: A clear strobe zeroes the occupancy, both indices, the teardown flag and the overflow flag in one cycle. A configuration write does the same and also loads the new base, size, element-size code and mode.
- R10: Doorbell writes take effect only while the ring's 2-bit mode code is 0 (ring mode). For any other mode they leave the count and the indices unchanged.
- R11: Ring windows are 0x1000 bytes apart: bus address bits 12 and up select the ring. A doorbell write to one ring leaves every other ring's state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12+RING_W | Register bus byte address: ring select above bit 11, window offset below |
| busWdata | input | 32 | Register bus write data |
| busWe | input | 1 | Register bus write enable |
| busRdata | output | 32 | Register bus read data for the addressed register |
| cfgWe | input | 1 | Configuration load strobe |
| cfgRing | input | RING_W | Ring selected for configuration |
| cfgBase | input | ADDR_W | Ring base address |
| cfgSize | input | SIZE_W | Ring size in elements |
| cfgElemSize | input | 3 | Element-size code, element bytes = 4 << code |
| cfgMode | input | 2 | Mode code, 0 is ring mode |
| tdownEvt | input | NUM_RINGS | Per-ring teardown completion event |
| ringClr | input | NUM_RINGS | Per-ring state clear strobe |
| wrElemAddr | output | NUM_RINGS*ADDR_W | Per-ring address of the next element to write |
| rdElemAddr | output | NUM_RINGS*ADDR_W | Per-ring address of the next element to read |
| ovfErr | output | NUM_RINGS | Per-ring sticky overflow flag |

## Verification
The bound checker watches every cycle for five properties:
- a ring's occupancy changes only when a doorbell, clear or configuration is aimed at that ring;
- both indices stay below a nonzero ring size;
- the overflow flag falls only after a clear or a configuration write;
- a teardown event always leaves the flag set;
- a clear always leaves the ring empty.

The arithmetic itself can only be shown by the directed scenarios. These cover signed counts, the modulo-2^21 wrap below zero and above the maximum, index wrap at a small ring size, element address scaling by size code, register field placement, and mode gating.

// File: rtl/ringdb_pkg.sv
`timescale 1ns/1ps
package ringdb_pkg;
  localparam int BUS_DW = 32;
  localparam int CNT_W  = 8;
  localparam int RSEL_W = 8;
  localparam int TD_BIT = 31;

  localparam logic [11:0] OFS_DOORBELL = 12'h010;
  localparam logic [11:0] OFS_OCC      = 12'h018;
  localparam logic [11:0] OFS_FREE     = 12'h01C;
  localparam logic [11:0] OFS_WIDX     = 12'h020;
  localparam logic [11:0] OFS_RIDX     = 12'h024;

  typedef enum logic [1:0] {
    MODE_RING = 2'd0,
    MODE_MSG  = 2'd1,
    MODE_CRED = 2'd2,
    MODE_QMGR = 2'd3
  } ringMode_e;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_OCC  = 3'd1,
    RD_FREE = 3'd2,
    RD_WIDX = 3'd3,
    RD_RIDX = 3'd4
  } rdSel_e;

  // strobes from the bus decoder to the datapath
  typedef struct packed {
    logic                     dbHit;
    logic [RSEL_W-1:0]        ring;
    logic [CNT_W-1:0]         cnt;
    logic                     tdAck;
    logic [RSEL_W-1:0]        rdRing;
    rdSel_e                   rdSel;
  } dbStrobe_t;
endpackage

// File: rtl/ringdb_ctrl.sv
`timescale 1ns/1ps
module ringdb_ctrl
  import ringdb_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int RING_W    = 2,
  parameter int BUS_AW    = 14
) (
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [BUS_DW-1:0] busWdata,
  input  logic              busWe,
  output dbStrobe_t         strb
);
  logic [11:0]       ofs;
  logic [RING_W-1:0] ringF;
  logic              inRange;
  logic              unusedWdata;

  assign ofs         = busAddr[11:0];
  assign ringF       = busAddr[12 +: RING_W];
  assign inRange     = ({1'b0, ringF} < (RING_W+1)'(NUM_RINGS));
  assign unusedWdata = ^busWdata[TD_BIT-1:CNT_W];

  always_comb begin
    strb        = '0;
    strb.ring   = RSEL_W'(ringF);
    strb.rdRing = RSEL_W'(ringF);
    strb.cnt    = busWdata[CNT_W-1:0];
    strb.tdAck  = busWdata[TD_BIT];
    strb.dbHit  = busWe && (ofs == OFS_DOORBELL) && inRange;
    strb.rdSel  = RD_NONE;
    if (inRange) begin
      case (ofs)
        OFS_OCC:  strb.rdSel = RD_OCC;
        OFS_FREE: strb.rdSel = RD_FREE;
        OFS_WIDX: strb.rdSel = RD_WIDX;
        OFS_RIDX: strb.rdSel = RD_RIDX;
        default:  strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ringdb_datapath.sv
`timescale 1ns/1ps
module ringdb_datapath
  import ringdb_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int RING_W    = 2,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 20,
  parameter int OCC_W     = 21
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dbStrobe_t                   strb,
  input  logic                        cfgWe,
  input  logic [RING_W-1:0]           cfgRing,
  input  logic [ADDR_W-1:0]           cfgBase,
  input  logic [SIZE_W-1:0]           cfgSize,
  input  logic [2:0]                  cfgElemSize,
  input  logic [1:0]                  cfgMode,
  input  logic [NUM_RINGS-1:0]        tdownEvt,
  input  logic [NUM_RINGS-1:0]        ringClr,
  output logic [BUS_DW-1:0]           busRdata,
  output logic [NUM_RINGS*ADDR_W-1:0] wrElemAddr,
  output logic [NUM_RINGS*ADDR_W-1:0] rdElemAddr,
  output logic [NUM_RINGS-1:0]        ovfErr,
  output logic [NUM_RINGS*OCC_W-1:0]  occFlat,
  output logic [NUM_RINGS*SIZE_W-1:0] wIdxFlat,
  output logic [NUM_RINGS*SIZE_W-1:0] rIdxFlat,
  output logic [NUM_RINGS*SIZE_W-1:0] sizeFlat,
  output logic [NUM_RINGS-1:0]        tdFlag
);
  localparam int MAG_W = CNT_W + 1;

  logic [OCC_W-1:0]  occArr  [NUM_RINGS];
  logic [OCC_W-1:0]  freeArr [NUM_RINGS];
  logic [SIZE_W-1:0] wIdxArr [NUM_RINGS];
  logic [SIZE_W-1:0] rIdxArr [NUM_RINGS];
  logic [SIZE_W-1:0] sizeArr [NUM_RINGS];

  // shared index/occupancy unit: one doorbell write per cycle at most
  logic [RING_W-1:0] selR, rdR;
  logic              unusedRingHi;
  logic [CNT_W-1:0]  cnt;
  logic              isPush, isPop;
  logic [MAG_W-1:0]  mag;
  logic [SIZE_W-1:0] curIdx, selSize, nextIdx;
  logic [SIZE_W:0]   idxSum;
  logic [OCC_W-1:0]  occNext;
  logic              ovfNow;

  assign selR         = strb.ring[RING_W-1:0];
  assign rdR          = strb.rdRing[RING_W-1:0];
  assign unusedRingHi = |(strb.ring >> RING_W) | |(strb.rdRing >> RING_W);
  assign cnt          = strb.cnt;
  assign isPop        = cnt[CNT_W-1];
  assign isPush       = !cnt[CNT_W-1] && (cnt != '0);
  assign mag          = isPop ? (MAG_W'(0) - {1'b1, cnt}) : {1'b0, cnt};
  assign curIdx       = isPush ? wIdxArr[selR] : rIdxArr[selR];
  assign selSize      = sizeArr[selR];
  assign idxSum       = (SIZE_W+1)'(curIdx) + (SIZE_W+1)'(mag);
  assign nextIdx      = (selSize == '0) ? '0
                        : SIZE_W'(idxSum % (SIZE_W+1)'(selSize));
  assign occNext      = occArr[selR] + {{(OCC_W-CNT_W){cnt[CNT_W-1]}}, cnt};
  assign ovfNow       = isPush && (freeArr[selR] == '0);

  for (genvar g = 0; g < NUM_RINGS; g++) begin : gRing
    logic [ADDR_W-1:0] baseQ;
    logic [SIZE_W-1:0] sizeQ;
    logic [2:0]        eszQ;
    ringMode_e         modeQ;
    logic [OCC_W-1:0]  occQ;
    logic [SIZE_W-1:0] wIdxQ, rIdxQ;
    logic              tdQ, ovfQ;
    logic              hitDb, hitCfg;
    logic [3:0]        shamt;

    assign hitCfg = cfgWe && (cfgRing == RING_W'(g));
    assign hitDb  = strb.dbHit && (selR == RING_W'(g)) && (modeQ == MODE_RING);
    assign shamt  = {1'b0, eszQ} + 4'd2;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        sizeQ <= '0;
        eszQ  <= '0;
        modeQ <= MODE_RING;
        occQ  <= '0;
        wIdxQ <= '0;
        rIdxQ <= '0;
        tdQ   <= 1'b0;
        ovfQ  <= 1'b0;
      end else if (hitCfg) begin
        baseQ <= cfgBase;
        sizeQ <= cfgSize;
        eszQ  <= cfgElemSize;
        modeQ <= ringMode_e'(cfgMode);
        occQ  <= '0;
        wIdxQ <= '0;
        rIdxQ <= '0;
        tdQ   <= 1'b0;
        ovfQ  <= 1'b0;
      end else if (ringClr[g]) begin
        occQ  <= '0;
        wIdxQ <= '0;
        rIdxQ <= '0;
        tdQ   <= 1'b0;
        ovfQ  <= 1'b0;
      end else begin
        if (hitDb) begin
          occQ <= occNext;
          if (isPush) wIdxQ <= nextIdx;
          if (isPop)  rIdxQ <= nextIdx;
          if (ovfNow) ovfQ  <= 1'b1;
        end
        if (tdownEvt[g])
          tdQ <= 1'b1;
        else if (hitDb && strb.tdAck)
          tdQ <= 1'b0;
      end
    end

    assign occArr[g]  = occQ;
    assign freeArr[g] = OCC_W'(sizeQ) - occQ;
    assign wIdxArr[g] = wIdxQ;
    assign rIdxArr[g] = rIdxQ;
    assign sizeArr[g] = sizeQ;

    assign wrElemAddr[g*ADDR_W +: ADDR_W] = baseQ + (ADDR_W'(wIdxQ) << shamt);
    assign rdElemAddr[g*ADDR_W +: ADDR_W] = baseQ + (ADDR_W'(rIdxQ) << shamt);
    assign ovfErr[g]                      = ovfQ;
    assign tdFlag[g]                      = tdQ;
    assign occFlat[g*OCC_W +: OCC_W]      = occQ;
    assign wIdxFlat[g*SIZE_W +: SIZE_W]   = wIdxQ;
    assign rIdxFlat[g*SIZE_W +: SIZE_W]   = rIdxQ;
    assign sizeFlat[g*SIZE_W +: SIZE_W]   = sizeQ;
  end

  always_comb begin
    busRdata = '0;
    case (strb.rdSel)
      RD_OCC:  busRdata = {tdFlag[rdR], {(TD_BIT-OCC_W){1'b0}}, occArr[rdR]};
      RD_FREE: busRdata = BUS_DW'(freeArr[rdR]);
      RD_WIDX: busRdata = BUS_DW'(wIdxArr[rdR]);
      RD_RIDX: busRdata = BUS_DW'(rIdxArr[rdR]);
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ringdb_top.sv
`timescale 1ns/1ps
module ringdb_top
  import ringdb_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 20,
  localparam int RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
  localparam int BUS_AW   = 12 + RING_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [BUS_AW-1:0]           busAddr,
  input  logic [BUS_DW-1:0]           busWdata,
  input  logic                        busWe,
  output logic [BUS_DW-1:0]           busRdata,
  input  logic                        cfgWe,
  input  logic [RING_W-1:0]           cfgRing,
  input  logic [ADDR_W-1:0]           cfgBase,
  input  logic [SIZE_W-1:0]           cfgSize,
  input  logic [2:0]                  cfgElemSize,
  input  logic [1:0]                  cfgMode,
  input  logic [NUM_RINGS-1:0]        tdownEvt,
  input  logic [NUM_RINGS-1:0]        ringClr,
  output logic [NUM_RINGS*ADDR_W-1:0] wrElemAddr,
  output logic [NUM_RINGS*ADDR_W-1:0] rdElemAddr,
  output logic [NUM_RINGS-1:0]        ovfErr
);
  localparam int OCC_W = SIZE_W + 1;

  dbStrobe_t                   strb;
  logic [NUM_RINGS*OCC_W-1:0]  occFlat;
  logic [NUM_RINGS*SIZE_W-1:0] wIdxFlat;
  logic [NUM_RINGS*SIZE_W-1:0] rIdxFlat;
  logic [NUM_RINGS*SIZE_W-1:0] sizeFlat;
  logic [NUM_RINGS-1:0]        tdFlag;

  ringdb_ctrl #(
    .NUM_RINGS(NUM_RINGS), .RING_W(RING_W), .BUS_AW(BUS_AW)
  ) u_ctrl (
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .strb(strb)
  );

  ringdb_datapath #(
    .NUM_RINGS(NUM_RINGS), .RING_W(RING_W), .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W), .OCC_W(OCC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgWe(cfgWe), .cfgRing(cfgRing), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgElemSize(cfgElemSize), .cfgMode(cfgMode),
    .tdownEvt(tdownEvt), .ringClr(ringClr),
    .busRdata(busRdata), .wrElemAddr(wrElemAddr), .rdElemAddr(rdElemAddr),
    .ovfErr(ovfErr), .occFlat(occFlat), .wIdxFlat(wIdxFlat),
    .rIdxFlat(rIdxFlat), .sizeFlat(sizeFlat), .tdFlag(tdFlag)
  );
endmodule

// File: rtl/ringdb_chk.sv
`timescale 1ns/1ps
module ringdb_chk #(
  parameter int NUM_RINGS = 4,
  parameter int SIZE_W    = 20,
  localparam int RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
  localparam int BUS_AW   = 12 + RING_W,
  localparam int OCC_W    = SIZE_W + 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [BUS_AW-1:0]           busAddr,
  input logic                        busWe,
  input logic                        cfgWe,
  input logic [RING_W-1:0]           cfgRing,
  input logic [NUM_RINGS-1:0]        tdownEvt,
  input logic [NUM_RINGS-1:0]        ringClr,
  input logic [NUM_RINGS-1:0]        ovfErr,
  input logic [NUM_RINGS*OCC_W-1:0]  occFlat,
  input logic [NUM_RINGS*SIZE_W-1:0] wIdxFlat,
  input logic [NUM_RINGS*SIZE_W-1:0] rIdxFlat,
  input logic [NUM_RINGS*SIZE_W-1:0] sizeFlat,
  input logic [NUM_RINGS-1:0]        tdFlag
);
  for (genvar g = 0; g < NUM_RINGS; g++) begin : gChk
    logic dbToRing, cfgToRing;
    assign dbToRing  = busWe && (busAddr[11:0] == 12'h010) &&
                       (busAddr[12 +: RING_W] == RING_W'(g));
    assign cfgToRing = cfgWe && (cfgRing == RING_W'(g));

    // R2
    occ_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!dbToRing && !ringClr[g] && !cfgToRing)
      |=> $stable(occFlat[g*OCC_W +: OCC_W]));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sizeFlat[g*SIZE_W +: SIZE_W] != '0)
      |-> (wIdxFlat[g*SIZE_W +: SIZE_W] < sizeFlat[g*SIZE_W +: SIZE_W]) &&
          (rIdxFlat[g*SIZE_W +: SIZE_W] < sizeFlat[g*SIZE_W +: SIZE_W]));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ovfErr[g]) |-> $past(ringClr[g] || cfgToRing));

    // R8
    td_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tdownEvt[g] && !ringClr[g] && !cfgToRing) |=> tdFlag[g]);

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ringClr[g] && !cfgToRing)
      |=> (occFlat[g*OCC_W +: OCC_W] == '0) &&
          (wIdxFlat[g*SIZE_W +: SIZE_W] == '0) &&
          (rIdxFlat[g*SIZE_W +: SIZE_W] == '0) && !tdFlag[g] && !ovfErr[g]);
  end
endmodule

bind ringdb_top ringdb_chk #(.NUM_RINGS(NUM_RINGS), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/ringdb_top_bench.sv
`timescale 1ns/1ps
module ringdb_top_bench;
  localparam int NR     = 4;
  localparam int AW     = 32;
  localparam int SW     = 20;
  localparam int RW     = 2;
  localparam int BAW    = 12 + RW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [BAW-1:0]  busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic            busWe = 1'b0;
  logic [31:0]     busRdata;
  logic            cfgWe = 1'b0;
  logic [RW-1:0]   cfgRing = '0;
  logic [AW-1:0]   cfgBase = '0;
  logic [SW-1:0]   cfgSize = '0;
  logic [2:0]      cfgElemSize = '0;
  logic [1:0]      cfgMode = '0;
  logic [NR-1:0]   tdownEvt = '0;
  logic [NR-1:0]   ringClr = '0;
  logic [NR*AW-1:0] wrElemAddr, rdElemAddr;
  logic [NR-1:0]   ovfErr;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ringdb_top u_ringdb_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic dbWr(input int r, input logic [31:0] v);
    @(negedge clk);
    busAddr  = {RW'(r), 12'h010};
    busWdata = v;
    busWe    = 1'b1;
    @(negedge clk);
    busWe    = 1'b0;
  endtask

  task automatic rdReg(input int r, input logic [11:0] ofs, output logic [31:0] v);
    busAddr = {RW'(r), ofs};
    #1;
    v = busRdata;
  endtask

  task automatic cfg(input int r, input logic [31:0] base, input logic [SW-1:0] sz,
                     input logic [2:0] esz, input logic [1:0] md);
    @(negedge clk);
    cfgWe = 1'b1; cfgRing = RW'(r); cfgBase = base; cfgSize = sz;
    cfgElemSize = esz; cfgMode = md;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] v;
    for (int r = 0; r < NR; r++) begin
      rdReg(r, 12'h018, v); chk("R1 occ", v, 0);
      rdReg(r, 12'h01C, v); chk("R1 free", v, 0);
      rdReg(r, 12'h020, v); chk("R1 widx", v, 0);
      rdReg(r, 12'h024, v); chk("R1 ridx", v, 0);
      chk("R1 wraddr", wrElemAddr[r*AW +: AW], 0);
    end
    chk("R1 ovf", 32'(ovfErr), 0);
  endtask

  task automatic tPushPop();
    logic [31:0] v;
    cfg(0, 32'h1000_0000, 20'd5, 3'd1, 2'd0);
    repeat (3) dbWr(0, 32'h0000_0001);
    rdReg(0, 12'h018, v); chk("R2 occ after 3 push", v, 3);
    rdReg(0, 12'h020, v); chk("R4 widx", v, 3);
    chk("R5 wraddr", wrElemAddr[0 +: AW], 32'h1000_0018);
    rdReg(0, 12'h01C, v); chk("R6 free", v, 2);
    dbWr(0, 32'h0000_00FF);
    rdReg(0, 12'h018, v); chk("R2 occ after pop", v, 2);
    rdReg(0, 12'h024, v); chk("R4 ridx", v, 1);
    chk("R5 rdaddr", rdElemAddr[0 +: AW], 32'h1000_0008);
    dbWr(0, 32'h0000_1203);
    rdReg(0, 12'h018, v); chk("R2 upper bits ignored", v, 5);
    rdReg(0, 12'h020, v); chk("R4 widx wrap", v, 1);
    rdReg(0, 12'h01C, v); chk("R6 free zero", v, 0);
    chk("R7 no ovf yet", 32'(ovfErr[0]), 0);
    dbWr(0, 32'h0000_0001);
    chk("R7 ovf set", 32'(ovfErr[0]), 1);
    rdReg(0, 12'h018, v); chk("R7 occ still moves", v, 6);
    dbWr(0, 32'h0000_00FC);
    rdReg(0, 12'h018, v); chk("R2 pop four", v, 2);
    rdReg(0, 12'h024, v); chk("R4 ridx wrap", v, 0);
    chk("R7 ovf sticky", 32'(ovfErr[0]), 1);
  endtask

  task automatic tClear();
    logic [31:0] v;
    @(negedge clk); ringClr = 4'b0001;
    @(negedge clk); ringClr = '0;
    rdReg(0, 12'h018, v); chk("R9 occ clr", v, 0);
    rdReg(0, 12'h020, v); chk("R9 widx clr", v, 0);
    chk("R9 ovf clr", 32'(ovfErr[0]), 0);
    chk("R9 addr at base", wrElemAddr[0 +: AW], 32'h1000_0000);
  endtask

  task automatic tWrap();
    logic [31:0] v;
    cfg(1, 32'h0, 20'hFFFFF, 3'd0, 2'd0);
    dbWr(1, 32'h0000_00FF);
    rdReg(1, 12'h018, v); chk("R3 wrap below zero", v, 32'h001F_FFFF);
    dbWr(1, 32'h0000_007F);
    rdReg(1, 12'h018, v); chk("R3 wrap above max", v, 32'h0000_007E);
  endtask

  task automatic tTeardown();
    logic [31:0] v;
    @(negedge clk); tdownEvt = 4'b0010;
    @(negedge clk); tdownEvt = '0;
    rdReg(1, 12'h018, v); chk("R8 flag in bit31", v, 32'h8000_007E);
    dbWr(1, 32'h8000_0002);
    rdReg(1, 12'h018, v); chk("R8 ack clears, R2 bit31 not counted", v, 32'h0000_0080);
    @(negedge clk);
    busAddr = {2'd1, 12'h010}; busWdata = 32'h8000_0000; busWe = 1'b1;
    tdownEvt = 4'b0010;
    @(negedge clk); busWe = 1'b0; tdownEvt = '0;
    rdReg(1, 12'h018, v); chk("R8 event wins", v, 32'h8000_0080);
    cfg(1, 32'h0, 20'd8, 3'd0, 2'd0);
    rdReg(1, 12'h018, v); chk("R9 config clears", v, 0);
  endtask

  task automatic tMode();
    logic [31:0] v;
    cfg(2, 32'h0, 20'd8, 3'd0, 2'd1);
    dbWr(2, 32'h0000_0001);
    rdReg(2, 12'h018, v); chk("R10 ignored occ", v, 0);
    rdReg(2, 12'h020, v); chk("R10 ignored widx", v, 0);
    cfg(2, 32'h0, 20'd8, 3'd0, 2'd0);
    dbWr(2, 32'h0000_0001);
    rdReg(2, 12'h018, v); chk("R10 ring mode counts", v, 1);
  endtask

  task automatic tWindow();
    logic [31:0] v;
    cfg(3, 32'h2000_0000, 20'd16, 3'd6, 2'd0);
    dbWr(3, 32'h0000_0002);
    rdReg(3, 12'h018, v); chk("R11 ring3 occ", v, 2);
    chk("R5 esz6 addr", wrElemAddr[3*AW +: AW], 32'h2000_0200);
    rdReg(2, 12'h018, v); chk("R11 ring2 untouched", v, 1);
    rdReg(0, 12'h018, v); chk("R11 ring0 untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tPushPop();
    tClear();
    tWrap();
    tTeardown();
    tMode();
    tWindow();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule